// File: doc/BRIEF.md
# AXI Read Traffic Checker

This block generates AXI read-address traffic from a stream of read jobs and checks the read data that comes back. Each job carries a start address, a byte length and a transaction ID. For each job the block issues one incrementing burst at full bus width. It records the ID, the beat count and the size of the final beat in an in-order tracking FIFO. The expected bytes arrive one at a time on a separate reference input. They are packed little-endian into beats that match the current outstanding job.

Every accepted R beat is compared lane by lane against its packed reference beat. On a short final beat, lanes past the job length are masked out of the comparison. The block also checks each RID against the ID of the oldest outstanding request, checks RRESP for a non-OKAY code, and checks that RLAST falls on the expected last beat. Error results are reported as one-cycle pulses, sticky flags and saturating counters, so the block can serve as a synthesizable traffic checker in a hardware self-test.

Top module: `axrc_read_checker`

## Requirements
- R1: Each job accepted on the job input produces exactly one AR transaction. While `ar_valid_o` is high and `ar_ready_i` is low, the AR address, ID and length stay unchanged.
- R2: The AR fields are as follows. ARADDR equals the job address and ARID equals the job ID. ARLEN equals ceil(bytes / (DATA_W/8)) - 1. ARSIZE equals log2(DATA_W/8). ARBURST equals 2'b01 (INCR).
- R3: Reference byte k of a job goes to byte lane k mod (DATA_W/8), bits [8*lane+7:8*lane], of beat floor(k / (DATA_W/8)).
- R4: On the final beat of a job, lanes at or beyond the job's valid byte count are not compared. A difference there changes neither `data_error_o` nor `mismatch_cnt_o`.
- R5: Any byte mismatch in a compared lane sets `data_error_o`, which stays high until reset. The same mismatch increments `mismatch_cnt_o` by one per failing beat, saturating at its maximum.
- R6: Responses are matched to requests in issue order. If an accepted beat's RID differs from the ID of the oldest outstanding request, `id_error_o` is high for the one cycle after that beat.
- R7: An accepted beat with RRESP other than 2'b00 makes `resp_error_o` high for the one cycle after that beat.
- R8: If RLAST is high on a beat that is not the expected final beat, or low on the expected final beat, `protocol_error_o` is set and stays high until reset.
- R9: `r_ready_o` is high only while a request is outstanding and a full reference beat for the current R beat has been packed. Otherwise it is low.
- R10: `job_ready_o` is low while an AR is waiting for acceptance or while DEPTH requests are outstanding. `done_cnt_o` increments once for each job whose final beat is accepted.
- R11: After reset, `ar_valid_o`, `r_ready_o`, `ref_ready_o`, all error flags and both counters are 0, and `job_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| job_valid_i | input | 1 | Job offered |
| job_ready_o | output | 1 | Job accepted when high with valid |
| job_addr_i | input | ADDR_W | Job start address, bus-width aligned |
| job_bytes_i | input | LEN_W | Job byte length, at least 1 |
| job_id_i | input | ID_W | Job transaction ID |
| ref_valid_i | input | 1 | Reference byte offered |
| ref_ready_o | output | 1 | Reference byte accepted when high with valid |
| ref_byte_i | input | 8 | Expected data byte |
| ar_valid_o | output | 1 | AR valid |
| ar_ready_i | input | 1 | AR ready |
| ar_addr_o | output | ADDR_W | AR address |
| ar_id_o | output | ID_W | AR ID |
| ar_len_o | output | 8 | AR burst length minus one |
| ar_size_o | output | 3 | AR beat size code |
| ar_burst_o | output | 2 | AR burst type |
| r_valid_i | input | 1 | R valid |
| r_ready_o | output | 1 | R ready |
| r_data_i | input | DATA_W | R data |
| r_id_i | input | ID_W | R ID |
| r_resp_i | input | 2 | R response code |
| r_last_i | input | 1 | R last beat marker |
| id_error_o | output | 1 | One-cycle pulse on RID mismatch |
| resp_error_o | output | 1 | One-cycle pulse on non-OKAY response |
| data_error_o | output | 1 | Sticky data mismatch flag |
| protocol_error_o | output | 1 | Sticky RLAST placement error |
| mismatch_cnt_o | output | CNT_W | Beats with a data mismatch, saturating |
| done_cnt_o | output | CNT_W | Completed jobs, saturating |

## Verification
The bench sweeps job lengths from one byte to three full beats, so every final-beat fill level from 1 to 4 lanes is exercised. For each length it checks the AR length against a value computed by the bench and confirms that clean data raises no flag. Targeted jobs then corrupt a single byte on either side of the length boundary. This separates masked lanes from compared lanes. Other jobs inject a wrong RID, an error RRESP or an early RLAST, so each error output is shown to react only to its own fault. Two jobs left outstanding at once fill the tracking FIFO, which checks both the in-order matching and the stall of the job input.

// File: rtl/axrc_pkg.sv
package axrc_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10
  } burst_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/axrc_id_fifo.sv
module axrc_id_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem_q [DEPTH];
  logic [PW:0]  wp_q, rp_q;

  assign empty_o = (wp_q == rp_q);
  assign full_o  = (wp_q[PW] != rp_q[PW]) && (wp_q[PW-1:0] == rp_q[PW-1:0]);
  assign rdata_o = mem_q[rp_q[PW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i)  rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q[PW-1:0]] <= wdata_i;
  end

  a_r10_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r6_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/axrc_ar_issue.sv
module axrc_ar_issue
  import axrc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned LEN_W  = 10,
  localparam int unsigned BPB   = DATA_W / 8,
  localparam int unsigned SZ    = $clog2(BPB),
  localparam int unsigned BW    = LEN_W - SZ + 1,
  localparam int unsigned LBW   = SZ + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              job_valid_i,
  output logic              job_ready_o,
  input  logic [ADDR_W-1:0] job_addr_i,
  input  logic [LEN_W-1:0]  job_bytes_i,
  input  logic [ID_W-1:0]   job_id_i,
  input  logic              fifo_full_i,
  output logic              push_o,
  output logic [ID_W-1:0]   push_id_o,
  output logic [BW-1:0]     push_beats_o,
  output logic [LBW-1:0]    push_lb_o,
  output logic              ar_valid_o,
  input  logic              ar_ready_i,
  output logic [ADDR_W-1:0] ar_addr_o,
  output logic [ID_W-1:0]   ar_id_o,
  output logic [7:0]        ar_len_o,
  output logic [2:0]        ar_size_o,
  output logic [1:0]        ar_burst_o
);
  logic [BW-1:0]  beats;
  logic [LBW-1:0] last_bytes;
  logic           accept;

  // ceil(bytes / BPB) without a divider
  assign beats      = {1'b0, job_bytes_i[LEN_W-1:SZ]} + BW'(|job_bytes_i[SZ-1:0]);
  assign last_bytes = (job_bytes_i[SZ-1:0] == '0) ? LBW'(BPB) : {1'b0, job_bytes_i[SZ-1:0]};

  assign job_ready_o  = !ar_valid_o && !fifo_full_i;
  assign accept       = job_valid_i && job_ready_o;
  assign push_o       = accept;
  assign push_id_o    = job_id_i;
  assign push_beats_o = beats;
  assign push_lb_o    = last_bytes;
  assign ar_size_o    = 3'(SZ);
  assign ar_burst_o   = BURST_INCR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_valid_o <= 1'b0;
      ar_addr_o  <= '0;
      ar_id_o    <= '0;
      ar_len_o   <= '0;
    end else if (accept) begin
      ar_valid_o <= 1'b1;
      ar_addr_o  <= job_addr_i;
      ar_id_o    <= job_id_i;
      ar_len_o   <= 8'(beats - 1'b1);
    end else if (ar_ready_i) begin
      ar_valid_o <= 1'b0;
    end
  end

  a_r1_ar_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o && !ar_ready_i |=> ar_valid_o && $stable(ar_addr_o)
                                  && $stable(ar_id_o) && $stable(ar_len_o));
  a_r10_no_job_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o |-> !push_o);
endmodule

// File: rtl/axrc_ref_packer.sv
module axrc_ref_packer #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BPB   = DATA_W / 8,
  localparam int unsigned LBW   = $clog2(BPB) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_valid_i,
  output logic              ref_ready_o,
  input  logic [7:0]        ref_byte_i,
  input  logic              active_i,
  input  logic [LBW-1:0]    need_i,
  input  logic              consume_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic [LBW-1:0] cnt_q;
  logic           acc;

  assign ref_ready_o = active_i && !full_o;
  assign acc         = ref_valid_i && ref_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      full_o <= 1'b0;
    end else if (consume_i) begin
      full_o <= 1'b0;
    end else if (acc) begin
      if (cnt_q + 1'b1 == need_i) begin
        full_o <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // little-endian: the n-th byte of a beat lands on lane n
  for (genvar l = 0; l < BPB; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   data_o[8*l +: 8] <= '0;
      else if (consume_i)                            data_o[8*l +: 8] <= '0;
      else if (acc && cnt_q == LBW'(l))              data_o[8*l +: 8] <= ref_byte_i;
    end
  end

  a_r9_no_fill_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |-> full_o);
endmodule

// File: rtl/axrc_r_check.sv
module axrc_r_check
  import axrc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned LEN_W  = 10,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned BPB   = DATA_W / 8,
  localparam int unsigned SZ    = $clog2(BPB),
  localparam int unsigned BW    = LEN_W - SZ + 1,
  localparam int unsigned LBW   = SZ + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  input  logic [ID_W-1:0]   head_id_i,
  input  logic [BW-1:0]     head_beats_i,
  input  logic [LBW-1:0]    head_lb_i,
  input  logic              ref_full_i,
  input  logic [DATA_W-1:0] ref_data_i,
  output logic [LBW-1:0]    need_o,
  output logic              consume_o,
  output logic              pop_o,
  input  logic              r_valid_i,
  output logic              r_ready_o,
  input  logic [DATA_W-1:0] r_data_i,
  input  logic [ID_W-1:0]   r_id_i,
  input  logic [1:0]        r_resp_i,
  input  logic              r_last_i,
  output logic              id_error_o,
  output logic              resp_error_o,
  output logic              data_error_o,
  output logic              protocol_error_o,
  output logic [CNT_W-1:0]  mismatch_cnt_o,
  output logic [CNT_W-1:0]  done_cnt_o
);
  logic [BW-1:0]  beat_q;
  logic           hs, is_last;
  logic [BPB-1:0] lane_bad;

  assign is_last   = (beat_q == head_beats_i - 1'b1);
  assign need_o    = is_last ? head_lb_i : LBW'(BPB);
  assign r_ready_o = !fifo_empty_i && ref_full_i;
  assign hs        = r_valid_i && r_ready_o;
  assign consume_o = hs;
  assign pop_o     = hs && is_last;

  for (genvar l = 0; l < BPB; l++) begin : g_cmp
    assign lane_bad[l] = (LBW'(l) < need_o) && (r_data_i[8*l +: 8] != ref_data_i[8*l +: 8]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q           <= '0;
      id_error_o       <= 1'b0;
      resp_error_o     <= 1'b0;
      data_error_o     <= 1'b0;
      protocol_error_o <= 1'b0;
      mismatch_cnt_o   <= '0;
      done_cnt_o       <= '0;
    end else begin
      id_error_o   <= hs && (r_id_i != head_id_i);
      resp_error_o <= hs && (r_resp_i != RESP_OKAY);
      if (pop_o)   beat_q <= '0;
      else if (hs) beat_q <= beat_q + 1'b1;
      if (hs && |lane_bad) begin
        data_error_o <= 1'b1;
        if (mismatch_cnt_o != '1) mismatch_cnt_o <= mismatch_cnt_o + 1'b1;
      end
      if (hs && (r_last_i != is_last)) protocol_error_o <= 1'b1;
      if (pop_o && done_cnt_o != '1) done_cnt_o <= done_cnt_o + 1'b1;
    end
  end

  a_r5_data_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_error_o |=> data_error_o);
  a_r8_protocol_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protocol_error_o |=> protocol_error_o);
  a_r9_ready_needs_job: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_ready_o |-> !fifo_empty_i);
  a_r10_done_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_o |=> $stable(done_cnt_o));
endmodule

// File: rtl/axrc_read_checker.sv
module axrc_read_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned LEN_W  = 10,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              job_valid_i,
  output logic              job_ready_o,
  input  logic [ADDR_W-1:0] job_addr_i,
  input  logic [LEN_W-1:0]  job_bytes_i,
  input  logic [ID_W-1:0]   job_id_i,
  input  logic              ref_valid_i,
  output logic              ref_ready_o,
  input  logic [7:0]        ref_byte_i,
  output logic              ar_valid_o,
  input  logic              ar_ready_i,
  output logic [ADDR_W-1:0] ar_addr_o,
  output logic [ID_W-1:0]   ar_id_o,
  output logic [7:0]        ar_len_o,
  output logic [2:0]        ar_size_o,
  output logic [1:0]        ar_burst_o,
  input  logic              r_valid_i,
  output logic              r_ready_o,
  input  logic [DATA_W-1:0] r_data_i,
  input  logic [ID_W-1:0]   r_id_i,
  input  logic [1:0]        r_resp_i,
  input  logic              r_last_i,
  output logic              id_error_o,
  output logic              resp_error_o,
  output logic              data_error_o,
  output logic              protocol_error_o,
  output logic [CNT_W-1:0]  mismatch_cnt_o,
  output logic [CNT_W-1:0]  done_cnt_o
);
  localparam int unsigned BPB = DATA_W / 8;
  localparam int unsigned SZ  = $clog2(BPB);
  localparam int unsigned BW  = LEN_W - SZ + 1;
  localparam int unsigned LBW = SZ + 1;
  localparam int unsigned EW  = ID_W + BW + LBW;

  logic              push, pop, f_empty, f_full, consume, ref_full;
  logic [ID_W-1:0]   push_id;
  logic [BW-1:0]     push_beats;
  logic [LBW-1:0]    push_lb, need;
  logic [EW-1:0]     head;
  logic [DATA_W-1:0] ref_data;

  axrc_ar_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .LEN_W(LEN_W)) u_issue (
    .clk_i, .rst_ni, .job_valid_i, .job_ready_o, .job_addr_i, .job_bytes_i, .job_id_i,
    .fifo_full_i(f_full), .push_o(push), .push_id_o(push_id), .push_beats_o(push_beats),
    .push_lb_o(push_lb), .ar_valid_o, .ar_ready_i, .ar_addr_o, .ar_id_o, .ar_len_o,
    .ar_size_o, .ar_burst_o
  );

  axrc_id_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .wdata_i({push_id, push_beats, push_lb}),
    .pop_i(pop), .rdata_o(head), .empty_o(f_empty), .full_o(f_full)
  );

  axrc_ref_packer #(.DATA_W(DATA_W)) u_pack (
    .clk_i, .rst_ni, .ref_valid_i, .ref_ready_o, .ref_byte_i, .active_i(!f_empty),
    .need_i(need), .consume_i(consume), .full_o(ref_full), .data_o(ref_data)
  );

  axrc_r_check #(.DATA_W(DATA_W), .ID_W(ID_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_check (
    .clk_i, .rst_ni, .fifo_empty_i(f_empty),
    .head_id_i(head[EW-1 -: ID_W]), .head_beats_i(head[LBW +: BW]), .head_lb_i(head[LBW-1:0]),
    .ref_full_i(ref_full), .ref_data_i(ref_data), .need_o(need), .consume_o(consume),
    .pop_o(pop), .r_valid_i, .r_ready_o, .r_data_i, .r_id_i, .r_resp_i, .r_last_i,
    .id_error_o, .resp_error_o, .data_error_o, .protocol_error_o, .mismatch_cnt_o, .done_cnt_o
  );
endmodule

// File: tb/tb_axrc_read_checker.sv
`timescale 1ns/1ps
module tb_axrc_read_checker;
  localparam int DW = 32, BPB = 4, IDW = 4, DEPTH = 2, CW = 16;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic job_valid = 0, ref_valid = 0, ar_ready = 0, r_valid = 0, r_last = 0;
  logic [31:0] job_addr = 0;
  logic [9:0]  job_bytes = 0;
  logic [IDW-1:0] job_id = 0, r_id = 0;
  logic [7:0]  ref_byte = 0;
  logic [DW-1:0] r_data = 0;
  logic [1:0]  r_resp = 0;
  logic job_ready, ref_ready, ar_valid, r_ready, id_err, resp_err, data_err, proto_err;
  logic [31:0] ar_addr;
  logic [IDW-1:0] ar_id;
  logic [7:0] ar_len;
  logic [2:0] ar_size;
  logic [1:0] ar_burst;
  logic [CW-1:0] mism_cnt, done_cnt;

  axrc_read_checker #(.DATA_W(DW), .ID_W(IDW), .DEPTH(DEPTH), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .job_valid_i(job_valid), .job_ready_o(job_ready),
    .job_addr_i(job_addr), .job_bytes_i(job_bytes), .job_id_i(job_id),
    .ref_valid_i(ref_valid), .ref_ready_o(ref_ready), .ref_byte_i(ref_byte),
    .ar_valid_o(ar_valid), .ar_ready_i(ar_ready), .ar_addr_o(ar_addr), .ar_id_o(ar_id),
    .ar_len_o(ar_len), .ar_size_o(ar_size), .ar_burst_o(ar_burst),
    .r_valid_i(r_valid), .r_ready_o(r_ready), .r_data_i(r_data), .r_id_i(r_id),
    .r_resp_i(r_resp), .r_last_i(r_last), .id_error_o(id_err), .resp_error_o(resp_err),
    .data_error_o(data_err), .protocol_error_o(proto_err),
    .mismatch_cnt_o(mism_cnt), .done_cnt_o(done_cnt)
  );

  int tests = 0, fails = 0, id_pulses = 0, resp_pulses = 0, exp_done = 0;

  always @(negedge clk) begin
    if (id_err)   id_pulses++;
    if (resp_err) resp_pulses++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(input int a);
    return 8'(a * 13 + 5);
  endfunction

  task automatic push_job(input int addr, input int len, input int id, input int stall);
    @(negedge clk);
    job_valid = 1; job_addr = addr; job_bytes = 10'(len); job_id = IDW'(id);
    while (!job_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    job_valid = 0;
    while (!ar_valid) @(negedge clk);
    chk(ar_addr == addr && ar_id == IDW'(id), "R2 addr/id", ar_addr, addr);
    chk(ar_len == 8'((len + BPB - 1) / BPB - 1) && ar_size == 3'd2 && ar_burst == 2'b01,
        "R2 len/size/burst", ar_len, (len + BPB - 1) / BPB - 1);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(ar_valid && ar_addr == addr && ar_len == 8'((len + BPB - 1) / BPB - 1),
          "R1 hold under stall", ar_valid, 1);
    end
    ar_ready = 1;
    @(posedge clk); @(negedge clk);
    ar_ready = 0;
    chk(!ar_valid, "R1 single AR", ar_valid, 0);
  endtask

  task automatic serve(input int addr, input int len, input int id, input int corrupt,
                       input int bad_id_beat, input int bad_resp_beat, input bit early_last);
    int beats = (len + BPB - 1) / BPB;
    fork
      begin
        for (int k = 0; k < len; k++) begin
          ref_valid = 1; ref_byte = mb(addr + k);
          while (!ref_ready) @(negedge clk);
          @(posedge clk); @(negedge clk);
        end
        ref_valid = 0;
      end
      begin
        for (int b = 0; b < beats; b++) begin
          for (int l = 0; l < BPB; l++) begin
            logic [7:0] v = mb(addr + b * BPB + l);
            if (b * BPB + l == corrupt) v = ~v;
            r_data[8*l +: 8] = v;
          end
          r_valid = 1;
          r_id   = (b == bad_id_beat) ? IDW'(id + 1) : IDW'(id);
          r_resp = (b == bad_resp_beat) ? 2'b10 : 2'b00;
          r_last = early_last ? (b == 0) : (b == beats - 1);
          while (!r_ready) @(negedge clk);
          @(posedge clk); @(negedge clk);
        end
        r_valid = 0; r_last = 0;
      end
    join
    exp_done++;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int mc, ip, rp;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!ar_valid && !r_ready && !ref_ready && !id_err && !resp_err && !data_err && !proto_err
        && mism_cnt == 0 && done_cnt == 0 && job_ready, "R11 reset", ar_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // R2/R3/R4 sweep of every length 1..12 with clean data
    for (int len = 1; len <= 12; len++) begin
      push_job(len * 64, len, len % 16, (len == 3) ? 3 : 0);
      chk(!r_ready, "R9 no ready before reference", r_ready, 0);
      serve(len * 64, len, len % 16, -1, -1, -1, 0);
      chk(!data_err && mism_cnt == 0 && !proto_err && id_pulses == 0 && resp_pulses == 0,
          "R3 clean sweep", mism_cnt, 0);
      chk(done_cnt == CW'(exp_done), "R10 done count", done_cnt, exp_done);
    end

    // R4 corrupt a lane past the length on the final beat
    push_job(32'h1000, 5, 3, 0);
    serve(32'h1000, 5, 3, 6, -1, -1, 0);
    chk(!data_err && mism_cnt == 0, "R4 masked lane", mism_cnt, 0);
    push_job(32'h1100, 7, 4, 0);
    serve(32'h1100, 7, 4, 7, -1, -1, 0);
    chk(!data_err && mism_cnt == 0, "R4 masked top lane", mism_cnt, 0);

    // R6 wrong RID on beat 1
    ip = id_pulses;
    push_job(32'h1200, 8, 5, 0);
    serve(32'h1200, 8, 5, -1, 1, -1, 0);
    chk(id_pulses == ip + 1, "R6 id pulse", id_pulses, ip + 1);

    // R7 error response
    rp = resp_pulses;
    push_job(32'h1300, 4, 6, 0);
    serve(32'h1300, 4, 6, -1, -1, 0, 0);
    chk(resp_pulses == rp + 1 && id_pulses == ip + 1, "R7 resp pulse", resp_pulses, rp + 1);
    chk(!proto_err && !data_err, "R7 no side flags", proto_err, 0);

    // R10 fill the tracking FIFO, then R6 in-order matching
    push_job(32'h1400, 6, 7, 0);
    push_job(32'h1500, 3, 8, 0);
    repeat (2) @(negedge clk);
    chk(!job_ready, "R10 stall when full", job_ready, 0);
    serve(32'h1400, 6, 7, -1, -1, -1, 0);
    chk(job_ready, "R10 ready after pop", job_ready, 1);
    serve(32'h1500, 3, 8, -1, -1, -1, 0);
    chk(id_pulses == ip + 1 && !data_err && done_cnt == CW'(exp_done), "R6 in order",
        done_cnt, exp_done);

    // R5 corrupt a counted lane on the short final beat
    push_job(32'h1600, 6, 9, 0);
    serve(32'h1600, 6, 9, 5, -1, -1, 0);
    chk(data_err && mism_cnt == 1, "R5 data error", mism_cnt, 1);
    mc = mism_cnt;
    push_job(32'h1700, 4, 10, 0);
    serve(32'h1700, 4, 10, 0, -1, -1, 0);
    chk(data_err && mism_cnt == CW'(mc + 1), "R5 count and sticky", mism_cnt, mc + 1);

    // R8 early RLAST
    chk(!proto_err, "R8 clean so far", proto_err, 0);
    push_job(32'h1800, 8, 11, 0);
    serve(32'h1800, 8, 11, -1, -1, -1, 1);
    chk(proto_err, "R8 early last", proto_err, 1);
    repeat (3) @(negedge clk);
    chk(proto_err && data_err, "R8 sticky", proto_err, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule